// File: doc/BRIEF.md
# Addressable Bit Bank with Four Control Modes

This block holds a bank of individually addressable storage bits, eight by default, and presents them together on a parallel output bus. A single serial data bit is steered into the bank through a binary select. Two active-low control inputs, an enable and a clear, are sampled together on each rising clock edge. Between them they choose one of four behaviours: hold everything, write only the selected bit, clear the whole bank, or demultiplex. In demultiplex mode the selected bit takes the data bit and every other bit is zeroed.

Every storage bit is a clocked register, and the output bus is taken straight from those registers. A synchronous active-high reset, separate from the clear input, empties the bank. Typical uses are setting individual control lines from a narrow source, and routing a single-bit strobe onto one of several lines.

Top module: `addr_latch_bank`

## Requirements
- R1: While `rst` is 1 at a rising edge, all bits of `q` are 0 after that edge, regardless of the other inputs.
- R2: Demultiplex mode: with `en_n`=0 and `clr_n`=0 at a rising edge, bit `sel` of `q` takes `din` and every other bit of `q` becomes 0.
- R3: Memory mode: with `en_n`=1 and `clr_n`=1 at a rising edge, `q` keeps its value, whatever `din` and `sel` are.
- R4: Addressable write mode: with `en_n`=0 and `clr_n`=1 at a rising edge, bit `sel` of `q` takes `din` and every other bit of `q` keeps its value.
- R5: Clear mode: with `en_n`=1 and `clr_n`=0 at a rising edge, every bit of `q` becomes 0, whatever `din` and `sel` are.
- R6: The select maps directly to a bit position: `sel`=k addresses `q[k]`, for every k from 0 to WIDTH-1.
- R7: `q` changes only at a rising clock edge. A change of `din`, `sel`, `en_n` or `clr_n` between edges does not reach `q` until the next edge.
- R8: In addressable write mode, after `sel` moves to a new position, the bit addressed before keeps the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; empties the bank |
| din | input | 1 | Serial data bit written into the selected position |
| sel | input | SEL_W (3) | Binary select of the addressed bit |
| en_n | input | 1 | Active-low enable; 0 lets the data bit in |
| clr_n | input | 1 | Active-low clear; 0 zeroes the bits that are not written |
| q | output | WIDTH (8) | Stored bits, one register per bit |

## Verification
The bench builds the block with its default values, WIDTH=8 and SEL_W=3, so the select can reach every position of the bank, including both ends. The bench drives all four enable/clear combinations and walks the select across every bit in both write modes. It fills the bank with varied patterns before each hold and clear, so that a bit that is wrongly kept or wrongly zeroed shows up on `q`. Before each edge it also reads `q` again, to show that an input change made between edges does not reach the output early.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } bank_mode_t;

  function automatic bank_mode_t decode_mode(input logic en_n, input logic clr_n);
    case ({en_n, clr_n})
      2'b00:   return MODE_DEMUX;
      2'b01:   return MODE_WRITE;
      2'b10:   return MODE_CLEAR;
      default: return MODE_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/addr_latch_mode_dec.sv
module addr_latch_mode_dec
  import addr_latch_pkg::*;
(
  input  logic       en_n,
  input  logic       clr_n,
  output bank_mode_t mode
);

  always_comb begin
    mode = decode_mode(en_n, clr_n);
  end

endmodule

// File: rtl/addr_latch_sel_dec.sv
module addr_latch_sel_dec #(
  parameter int WIDTH = 8,
  parameter int SEL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [SEL_W-1:0] sel,
  output logic [WIDTH-1:0] hit
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_hit
    localparam logic [SEL_W-1:0] POS = SEL_W'(i);
    assign hit[i] = (sel == POS);
  end

  always_comb begin
    assert ($onehot0(hit)) else $error("a_r6_single_hit: more than one position selected");
  end

endmodule

// File: rtl/addr_latch_bit_cell.sv
module addr_latch_bit_cell
  import addr_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bank_mode_t mode,
  input  logic       hit,
  input  logic       din,
  output logic       q
);

  logic q_next;

  always_comb begin
    case (mode)
      MODE_DEMUX: q_next = hit & din;
      MODE_WRITE: q_next = hit ? din : q;
      MODE_CLEAR: q_next = 1'b0;
      default:    q_next = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end

  // R4 / R8: an unaddressed bit in write mode keeps its value
  a_r4_unaddressed_keep: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WRITE && !hit) |=> $stable(q));

  // R4: the addressed bit in write mode takes the data bit
  a_r4_addressed_take: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WRITE && hit) |=> (q == $past(din)));

endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
  import addr_latch_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SEL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  input  logic             en_n,
  input  logic             clr_n,
  output logic [WIDTH-1:0] q
);

  bank_mode_t       mode;
  logic [WIDTH-1:0] hit;

  addr_latch_mode_dec u_mode (
    .en_n  (en_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  addr_latch_sel_dec #(
    .WIDTH (WIDTH),
    .SEL_W (SEL_W)
  ) u_sel (
    .sel (sel),
    .hit (hit)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    addr_latch_bit_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .hit  (hit[i]),
      .din  (din),
      .q    (q[i])
    );
  end

  // R1: reset empties the bank
  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (q == '0));

  // R3: memory mode holds the bank
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (en_n && clr_n) |=> $stable(q));

  // R5: clear mode zeroes the bank
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (en_n && !clr_n) |=> (q == '0));

  // R2: demultiplex mode leaves at most one bit set
  a_r2_demux_single: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr_n) |=> ($countones(q) <= 1));

  // R2: demultiplex mode with data 0 leaves the bank empty
  a_r2_demux_zero: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr_n && !din) |=> (q == '0));

endmodule

// File: tb/addr_latch_bank_tb.sv
module addr_latch_bank_tb;

  localparam int WIDTH = 8;
  localparam int SEL_W = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic             din;
  logic [SEL_W-1:0] sel;
  logic             en_n;
  logic             clr_n;
  logic [WIDTH-1:0] q;

  int total = 0;
  int bad   = 0;
  bit primed = 0;
  bit done   = 0;

  logic [WIDTH-1:0] model = '0;
  logic [WIDTH-1:0] exp_q[$];
  string            tag_q[$];

  always #5 clk = ~clk;

  addr_latch_bank #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_dut (
    .clk (clk), .rst (rst), .din (din), .sel (sel),
    .en_n (en_n), .clr_n (clr_n), .q (q)
  );

  task automatic check(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: q=%b expected=%b at %0t", tag, act, expv, $time);
    end
  endtask

  // driver: applies one edge's inputs and queues the expected result
  task automatic step(bit r, bit d, logic [SEL_W-1:0] s, bit e, bit c, string tag);
    logic [WIDTH-1:0] nxt;
    @(negedge clk);
    rst = r; din = d; sel = s; en_n = e; clr_n = c;
    nxt = model;
    if (r) nxt = '0;
    else begin
      case ({e, c})
        2'b00: begin nxt = '0; nxt[s] = d; end
        2'b01: nxt[s] = d;
        2'b10: nxt = '0;
        default: ;
      endcase
    end
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
    #3;
    // R7: new inputs must not reach q before the edge
    if (primed) check("R7", q, model);
    model = nxt;
    primed = 1;
  endtask

  // monitor: compares after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) check(tag_q.pop_front(), q, exp_q.pop_front());
  end

  initial begin
    rst = 1; din = 1; sel = 3'd5; en_n = 0; clr_n = 1;
    step(1, 1, 3'd5, 0, 1, "R1");
    step(1, 1, 3'd2, 0, 0, "R1");
    // R6 / R4: walk a one through every position in write mode
    for (int k = 0; k < WIDTH; k++) step(0, 1, 3'(k), 0, 1, "R6");
    // R3: hold a full bank while data and select toggle
    step(0, 0, 3'd3, 1, 1, "R3");
    step(0, 1, 3'd6, 1, 1, "R3");
    // R4: clear odd positions one at a time
    for (int k = 1; k < WIDTH; k += 2) step(0, 0, 3'(k), 0, 1, "R4");
    // R8: move the select, earlier bits keep their values
    step(0, 0, 3'd0, 0, 1, "R8");
    step(0, 1, 3'd7, 0, 1, "R8");
    step(0, 1, 3'd2, 1, 1, "R8");
    // R5: clear mode from a non-empty bank
    step(0, 1, 3'd4, 1, 0, "R5");
    step(0, 1, 3'd4, 0, 1, "R4");
    step(0, 1, 3'd1, 0, 1, "R4");
    // R2: demultiplex across every position, data 1 then 0
    for (int k = 0; k < WIDTH; k++) step(0, 1, 3'(WIDTH - 1 - k), 0, 0, "R2");
    step(0, 0, 3'd3, 0, 0, "R2");
    // R5 / R3: clear a mixed bank, then hold empty
    step(0, 1, 3'd5, 0, 1, "R4");
    step(0, 1, 3'd6, 0, 1, "R4");
    step(0, 0, 3'd5, 1, 0, "R5");
    step(0, 1, 3'd5, 1, 1, "R3");
    // R1: reset in the middle of a filled bank
    step(0, 1, 3'd7, 0, 1, "R4");
    step(1, 1, 3'd0, 0, 1, "R1");
    step(0, 0, 3'd0, 1, 1, "R3");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule